// File: doc/BRIEF.md
# Flash Operation Command Sequencer

This block turns register writes into erase and program requests for an on-chip nonvolatile array. Software loads a destination address, and optionally a RAM source address or four data words. It then writes the control register with an operation code, the enable bit and the go bit. The sequencer checks the request and forces the address alignment that the chosen operation needs. It then issues array requests one at a time over a request/done handshake. For a row write it first fetches each word from RAM over a request/valid read port.

While an operation runs, the go bit reads as busy. Only hardware clears it, in the cycle the last array request completes, and in that same cycle it sets a completion flag that drives the interrupt line. The array itself is modelled only as a handshake. Cell timing is left to whatever sits behind `arr_req`/`arr_done`.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and neither `ram_req` nor `arr_req` is asserted.
- R2: The register map is: address 0 control, 1 destination, 2 source, 4 to 7 data words 0 to 3; other addresses read 0. In control, bits [3:0] hold the operation code, bit 14 is enable, bit 15 is go/busy, bit 8 is the completion flag and bit 9 is the error flag. An operation starts when a control write carries bit 15 = 1, bit 14 = 1 and a listed code: 1110, 0100, 0011, 0010 or 0001.
- R3: A control write with bit 15 = 1 and bit 14 = 0 starts nothing and issues no array or RAM request.
- R4: A control write with bits 15 and 14 set and any other code starts nothing and sets the sticky error bit 9. Writing 1 to bit 9 clears it.
- R5: Control bit 15 reads 1 for the whole operation, and a control write of 0 to it while busy has no effect. It returns to 0 only when the operation completes.
- R6: Flag bit 8 and the `irq` output go to 1 in the same cycle that bit 15 returns to 0. Writing 1 to bit 8 clears both.
- R7: Code 0011 (page erase) issues one array request with `arr_cmd` = 1 at the destination address with bits [11:0] forced to 0.
- R8: Code 1110 (full erase) issues one request with `arr_cmd` = 3. Code 0100 (inactive-half erase) issues one request with `arr_cmd` = 2. Both use address 0.
- R9: Code 0001 (quadword write) issues four program requests (`arr_cmd` = 0). Request k goes to (destination with bits [3:0] cleared) + 4k and carries data word k.
- R10: Code 0010 (row write) performs 128 RAM reads from (source with bits [1:0] cleared) + 4k. Each read is followed by a program request (`arr_cmd` = 0) at (destination with bits [8:0] cleared) + 4k that carries the word read.
- R11: Source address bits [1:0] are not stored and read back as 0, and every RAM read address is word aligned.
- R12: While busy, writes to the destination, source and data registers and to the code and enable fields are ignored.
- R13: `arr_req` stays high with a stable address and command until `arr_done`. `ram_req` stays high with a stable address until `ram_valid`. The two requests are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| irq | output | 1 | Completion interrupt (level, mirrors flag bit 8) |
| ram_req | output | 1 | RAM read request, held until `ram_valid` |
| ram_addr | output | ADDR_W | RAM byte address, word aligned |
| ram_valid | input | 1 | RAM read data valid, one-cycle pulse |
| ram_rdata | input | 32 | RAM read data |
| arr_req | output | 1 | Array request, held until `arr_done` |
| arr_cmd | output | 2 | 0 program word, 1 page erase, 2 inactive-half erase, 3 full erase |
| arr_addr | output | ADDR_W | Array byte address |
| arr_wdata | output | 32 | Word to program |
| arr_done | input | 1 | Array completion, one-cycle pulse |

## Verification
The assertions assume that `arr_done` pulses for one cycle only while `arr_req` is high, and that `ram_valid` pulses for one cycle only while `ram_req` is high. If either side answered without a pending request, the hold and flag properties would no longer hold. The bench's array and RAM responders raise their answer only after seeing the matching request, and they drop it the following cycle. Every operation code is swept with two address patterns chosen so that the alignment masks actually clear set bits.

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
module flash_cmd_seq #(
  parameter int ADDR_W     = 24,
  parameter int ROW_WORDS  = 128,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              ram_req,
  output logic [ADDR_W-1:0] ram_addr,
  input  logic              ram_valid,
  input  logic [31:0]       ram_rdata,
  output logic              arr_req,
  output logic [1:0]        arr_cmd,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [31:0]       arr_wdata,
  input  logic              arr_done
);
  localparam int PAGE_LSB = $clog2(PAGE_BYTES);
  localparam int ROW_LSB  = $clog2(ROW_WORDS) + 2;
  localparam int QUAD_LSB = 4;
  localparam int CNT_W    = $clog2(ROW_WORDS) + 1;
  localparam logic [3:0] OP_FULL = 4'b1110, OP_PART = 4'b0100, OP_PAGE = 4'b0011,
                         OP_ROW  = 4'b0010, OP_QUAD = 4'b0001;

  typedef enum logic [1:0] {S_IDLE, S_ERASE, S_FETCH, S_PROG} state_t;

  state_t             state;
  logic [3:0]         op;
  logic               en, flag, err, is_row;
  logic [ADDR_W-1:0]  dst;
  logic [ADDR_W-1:2]  src;
  logic [31:0]        dq [4];
  logic [31:0]        word;
  logic [CNT_W-1:0]   idx, last;
  logic [1:0]         cmd;

  logic busy, ctrl_wr, req_go, known, start, bad, finish;
  logic [ADDR_W-1:0] step, page_a, row_a, quad_a;

  assign busy    = (state != S_IDLE);
  assign ctrl_wr = reg_wr && (reg_addr == 3'd0);
  assign req_go  = ctrl_wr && !busy && reg_wdata[15] && reg_wdata[14];
  assign known   = (reg_wdata[3:0] == OP_FULL) || (reg_wdata[3:0] == OP_PART) ||
                   (reg_wdata[3:0] == OP_PAGE) || (reg_wdata[3:0] == OP_ROW)  ||
                   (reg_wdata[3:0] == OP_QUAD);
  assign start   = req_go && known;
  assign bad     = req_go && !known;
  assign finish  = arr_done && ((state == S_ERASE) || (state == S_PROG && idx == last));

  assign step   = ADDR_W'(idx) << 2;
  assign page_a = {dst[ADDR_W-1:PAGE_LSB], {PAGE_LSB{1'b0}}};
  assign row_a  = {dst[ADDR_W-1:ROW_LSB],  {ROW_LSB{1'b0}}};
  assign quad_a = {dst[ADDR_W-1:QUAD_LSB], {QUAD_LSB{1'b0}}};

  assign irq       = flag;
  assign ram_req   = (state == S_FETCH);
  assign ram_addr  = {src, 2'b00} + step;
  assign arr_req   = (state == S_ERASE) || (state == S_PROG);
  assign arr_cmd   = cmd;
  assign arr_wdata = is_row ? word : dq[idx[1:0]];

  always_comb begin
    if (state == S_ERASE) arr_addr = (op == OP_PAGE) ? page_a : '0;
    else                  arr_addr = (is_row ? row_a : quad_a) + step;
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {16'b0, busy, en, 4'b0, err, flag, 4'b0, op};
      3'd1:    reg_rdata = 32'(dst);
      3'd2:    reg_rdata = 32'({src, 2'b00});
      3'd4, 3'd5, 3'd6, 3'd7: reg_rdata = dq[reg_addr[1:0]];
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op <= '0; en <= 1'b0; flag <= 1'b0; err <= 1'b0;
      dst <= '0; src <= '0;
      for (int i = 0; i < 4; i++) dq[i] <= '0;
    end else begin
      if (reg_wr && !busy) begin
        case (reg_addr)
          3'd0: begin op <= reg_wdata[3:0]; en <= reg_wdata[14]; end
          3'd1: dst <= reg_wdata[ADDR_W-1:0];
          3'd2: src <= reg_wdata[ADDR_W-1:2];
          3'd4, 3'd5, 3'd6, 3'd7: dq[reg_addr[1:0]] <= reg_wdata;
          default: ;
        endcase
      end
      if (ctrl_wr && reg_wdata[8]) flag <= 1'b0;
      if (ctrl_wr && reg_wdata[9]) err  <= 1'b0;
      if (bad)    err  <= 1'b1;
      if (finish) flag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; idx <= '0; last <= '0; is_row <= 1'b0; word <= '0; cmd <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          idx <= '0;
          case (reg_wdata[3:0])
            OP_FULL: begin state <= S_ERASE; cmd <= 2'd3; end
            OP_PART: begin state <= S_ERASE; cmd <= 2'd2; end
            OP_PAGE: begin state <= S_ERASE; cmd <= 2'd1; end
            OP_ROW:  begin state <= S_FETCH; cmd <= 2'd0; is_row <= 1'b1;
                           last <= CNT_W'(ROW_WORDS - 1); end
            default: begin state <= S_PROG;  cmd <= 2'd0; is_row <= 1'b0;
                           last <= CNT_W'(3); end
          endcase
        end
        S_ERASE: if (arr_done) state <= S_IDLE;
        S_FETCH: if (ram_valid) begin word <= ram_rdata; state <= S_PROG; end
        S_PROG: if (arr_done) begin
          if (idx == last) state <= S_IDLE;
          else begin
            idx   <= idx + 1'b1;
            state <= is_row ? S_FETCH : S_PROG;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
`timescale 1ns/1ps
module flash_cmd_seq_chk #(
  parameter int ADDR_W     = 24,
  parameter int PAGE_BYTES = 4096
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              irq,
  input logic              ram_req,
  input logic              ram_valid,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              arr_req,
  input logic              arr_done,
  input logic [1:0]        arr_cmd,
  input logic [ADDR_W-1:0] arr_addr
);
  p_arr_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req && !arr_done |=> arr_req && $stable(arr_addr) && $stable(arr_cmd));
  p_ram_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ram_req && !ram_valid |=> ram_req && $stable(ram_addr));
  p_one_side_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_req, arr_req}));
  p_word_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ram_req |-> ram_addr[1:0] == 2'b00);
  p_page_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req && arr_cmd == 2'd1 |-> (arr_addr % PAGE_BYTES) == 0);
  p_flag_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);
  p_flag_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $fell(busy));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .irq(irq),
  .ram_req(ram_req), .ram_valid(ram_valid), .ram_addr(ram_addr),
  .arr_req(arr_req), .arr_done(arr_done), .arr_cmd(arr_cmd), .arr_addr(arr_addr)
);

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;
  localparam int AW = 24;
  localparam logic [31:0] AMASK = 32'h00FF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, ram_req, ram_valid = 1'b0, arr_req, arr_done = 1'b0;
  logic [AW-1:0] ram_addr, arr_addr;
  logic [31:0] ram_rdata = '0, arr_wdata;
  logic [1:0] arr_cmd;

  int nchk = 0, nfail = 0, log_n = 0, acnt = 0;
  logic [1:0]  log_cmd  [512];
  logic [31:0] log_addr [512];
  logic [31:0] log_data [512];
  bit finished = 0;

  always #5 clk = ~clk;

  flash_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .ram_req(ram_req), .ram_addr(ram_addr), .ram_valid(ram_valid), .ram_rdata(ram_rdata),
    .arr_req(arr_req), .arr_cmd(arr_cmd), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .arr_done(arr_done));

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  always @(posedge clk) begin
    if (ram_req && !ram_valid) begin
      ram_valid <= 1'b1;
      ram_rdata <= pat(32'(ram_addr));
    end else ram_valid <= 1'b0;
  end

  always @(posedge clk) begin
    if (arr_req && arr_done) begin
      if (log_n < 512) begin
        log_cmd[log_n]  <= arr_cmd;
        log_addr[log_n] <= 32'(arr_addr);
        log_data[log_n] <= arr_wdata;
      end
      log_n    <= log_n + 1;
      arr_done <= 1'b0;
      acnt     <= 0;
    end else if (arr_req) begin
      if (acnt == 2) arr_done <= 1'b1;
      else acnt <= acnt + 1;
    end else begin
      arr_done <= 1'b0;
      acnt     <= 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 5000 && !irq; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, d, s, qd [4];
    logic [31:0] ex_a, ex_d;
    logic [1:0]  ex_c;
    int base, nexp;
    string tag;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reset register", v, 32'h0);
    end
    chk("R1 reset irq", 32'(irq), 32'h0);
    chk("R1 reset requests", 32'({ram_req, arr_req}), 32'h0);

    wr(2, 32'h0000_2003);
    rd(2, v);
    chk("R11 source low bits", v, 32'h0000_2000);

    base = log_n;
    wr(0, 32'h0000_8002);
    repeat (12) @(negedge clk);
    chk("R3 no request without enable", 32'(log_n - base), 32'h0);
    rd(0, v);
    chk("R3 busy/flag/error stay 0", {16'b0, v[15:8]}, 32'h0);
    chk("R3 irq stays 0", 32'(irq), 32'h0);

    for (int p = 0; p < 2; p++) begin
      d = p ? 32'h00FF_FFFF : 32'h0012_3ABC;
      s = p ? 32'h0000_07FF : 32'h0000_2003;
      wr(1, d);
      wr(2, s);
      for (int k = 0; k < 4; k++) begin
        qd[k] = pat(32'h100 + k + 8 * p);
        wr(3'(4 + k), qd[k]);
      end
      for (int o = 0; o < 16; o++) begin
        base = log_n;
        wr(0, 32'h0000_C000 | o);
        case (o)
          14: begin nexp = 1; tag = "R8"; end
          4:  begin nexp = 1; tag = "R8"; end
          3:  begin nexp = 1; tag = "R7"; end
          2:  begin nexp = 128; tag = "R10"; end
          1:  begin nexp = 4; tag = "R9"; end
          default: begin nexp = 0; tag = "R4"; end
        endcase
        if (nexp == 0) begin
          repeat (8) @(negedge clk);
          rd(0, v);
          chk("R4 error bit set, not busy", 32'({v[15], v[9]}), 32'h1);
          chk("R4 no array request", 32'(log_n - base), 32'h0);
          chk("R4 no irq", 32'(irq), 32'h0);
          wr(0, 32'h0000_0200);
          rd(0, v);
          chk("R4 error clear by W1C", 32'(v[9]), 32'h0);
        end else begin
          rd(0, v);
          chk("R5 busy reads 1", 32'(v[15]), 32'h1);
          wait_irq();
          @(negedge clk);
          rd(0, v);
          chk("R6 irq after completion", 32'(irq), 32'h1);
          chk("R5/R6 busy 0 flag 1", 32'({v[15], v[8]}), 32'h1);
          chk({tag, " request count"}, 32'(log_n - base), 32'(nexp));
          for (int k = 0; k < nexp; k++) begin
            case (o)
              14: begin ex_c = 2'd3; ex_a = 32'h0; end
              4:  begin ex_c = 2'd2; ex_a = 32'h0; end
              3:  begin ex_c = 2'd1; ex_a = d & ~32'hFFF; end
              2:  begin ex_c = 2'd0; ex_a = ((d & ~32'h1FF) + 4 * k) & AMASK;
                        ex_d = pat(((s & ~32'h3) + 4 * k) & AMASK); end
              default: begin ex_c = 2'd0; ex_a = ((d & ~32'hF) + 4 * k) & AMASK;
                        ex_d = qd[k]; end
            endcase
            if (k < 4 || k == nexp - 1 || p == 0) begin
              chk({tag, " array command"}, 32'(log_cmd[base + k]), 32'(ex_c));
              chk({tag, " array address"}, log_addr[base + k], ex_a);
              if (ex_c == 2'd0) chk({tag, " program data"}, log_data[base + k], ex_d);
            end
          end
          wr(0, 32'h0000_0100);
          chk("R6 irq clear by W1C", 32'(irq), 32'h0);
        end
      end
    end

    wr(1, 32'h0000_4400);
    wr(2, 32'h0000_0100);
    wr(4, 32'h1111_1111);
    base = log_n;
    wr(0, 32'h0000_C002);
    repeat (10) @(negedge clk);
    wr(1, 32'h00AB_CDEF);
    wr(2, 32'h0000_9000);
    wr(4, 32'h2222_2222);
    wr(0, 32'h0000_0001);
    rd(0, v);
    chk("R5 busy not cleared by write", 32'(v[15]), 32'h1);
    chk("R12 code/enable kept while busy", 32'({v[14], v[3:0]}), 32'h12);
    wait_irq();
    @(negedge clk);
    rd(1, v);
    chk("R12 destination kept", v, 32'h0000_4400);
    rd(2, v);
    chk("R12 source kept", v, 32'h0000_0100);
    rd(4, v);
    chk("R12 data kept", v, 32'h1111_1111);
    chk("R12 row address", log_addr[base + 127], 32'h0000_4400 + 4 * 127);
    chk("R12 row data", log_data[base + 127], pat(32'h100 + 4 * 127));
    chk("R2 row started", 32'(log_n - base), 32'd128);
    wr(0, 32'h0000_0100);
    chk("R6 irq cleared", 32'(irq), 32'h0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule